// File: doc/BRIEF.md
# Rounding Shift-Right Narrowing Unit

This block takes a vector of eight 16-bit lanes and scales every lane down by a right shift. Before the shift it adds half the weight of the last bit that the shift discards, so each lane is rounded to the nearest value. It then keeps only the low byte of each shifted lane. The eight bytes fill one half of a 128-bit destination word, and the other half is copied from the previous destination value that the caller supplies.

Two back-to-back operations can fill a whole register from two sources. The first uses the lower-half form. The second uses the upper-half form and feeds the first result back as the previous destination. This single step replaces three separate steps: a scaling shift, a width conversion and a slide. The most common shift amount is 3.

Top module: `rsn_unit`

## Requirements
- R1: Source lane i occupies `srcVec[16i+15:16i]`. With shift amount s from 1 to 15, its result byte is ((x + 2^(s-1)) >> s) mod 256, where x is the unsigned lane value.
- R2: The rounding sum is formed at 17 bits, so a carry out of bit 15 is kept before the shift. For example, 0xFFFF with s=1 gives byte 0x00 (from 0x8000), and 0xFF80 with s=8 gives 0x00 (from 0x100).
- R3: No saturation is applied; only the low 8 bits of the shifted value are kept. For example, 0x1234 with s=3 gives 0x47.
- R4: A shift amount of 0 adds no rounding term and shifts nothing, so the result byte is the low byte of the lane.
- R5: When `upperHalf` is 0, result byte i goes to `destOut[8i+7:8i]` and `destOut[127:64]` equals `prevDest[127:64]`.
- R6: When `upperHalf` is 1, result byte i goes to `destOut[64+8i+7:64+8i]` and `destOut[63:0]` equals `prevDest[63:0]`.
- R7: When `inValid` is high at a rising clock edge, the result appears on `destOut` after that edge, and `outValid` is high for exactly that one cycle.
- R8: When `inValid` is low at an edge, `destOut` keeps its value and `outValid` goes low. Other inputs have no effect.
- R9: While `rstN` is low, `destOut` is zero and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Start one operation this cycle |
| srcVec | input | 128 | Eight 16-bit source lanes, lane 0 in the low bits |
| shiftAmt | input | 4 | Right-shift amount; 0 means no shift and no rounding |
| upperHalf | input | 1 | 0 writes the low half of the destination, 1 writes the high half |
| prevDest | input | 128 | Earlier destination value; supplies the half that is kept |
| outValid | output | 1 | Result on `destOut` is new this cycle |
| destOut | output | 128 | Updated destination word |

## Verification
Every result is due exactly one rising edge after the cycle in which `inValid` is sampled. The expected value of `outValid` is low in every cycle that does not follow a request. The bench drives its inputs on the falling edge and updates its reference state at that same moment. At the next falling edge, after the single register stage has taken the request, it compares `destOut` and `outValid` against that reference. Idle cycles are compared in the same way, so holding behaviour is checked on every clock. Directed cases cover the carry-out, wrap-around, zero-shift and two-step packing corners, and a long random run covers the rest.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
  // Strobes handed from the control to the datapath each cycle.
  typedef struct packed {
    logic load;     // capture a new destination word
    logic upper;    // narrowed bytes go to the high half
    logic roundOn;  // add the half-LSB rounding term
  } rsnStrobe_t;
endpackage

// File: rtl/rsn_control.sv
module rsn_control #(
  parameter int SH_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                upperHalf,
  input  logic [SH_W-1:0]     shiftAmt,
  output rsn_pkg::rsnStrobe_t strobe,
  output logic                outValid
);
  always_comb begin
    strobe.load    = inValid;
    strobe.upper   = upperHalf;
    strobe.roundOn = (shiftAmt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/rsn_datapath.sv
module rsn_datapath #(
  parameter int LANES = 8,
  parameter int SRC_W = 16,
  parameter int DST_W = 8,
  parameter int SH_W  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rsn_pkg::rsnStrobe_t        strobe,
  input  logic [LANES*SRC_W-1:0]     srcVec,
  input  logic [SH_W-1:0]            shiftAmt,
  input  logic [2*LANES*DST_W-1:0]   prevDest,
  output logic [2*LANES*DST_W-1:0]   destOut
);
  localparam int HALF_W = LANES * DST_W;
  localparam int DEST_W = 2 * HALF_W;
  localparam int SUM_W  = SRC_W + 1;

  logic [HALF_W-1:0] narrowed;
  logic [DEST_W-1:0] nextDest;
  logic [SH_W-1:0]   biasPos;

  assign biasPos = shiftAmt - SH_W'(1);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [SUM_W-1:0] bias;
    logic [SUM_W-1:0] sumW;
    assign bias = strobe.roundOn ? (SUM_W'(1) << biasPos) : '0;
    assign sumW = {1'b0, srcVec[lane*SRC_W +: SRC_W]} + bias;
    assign narrowed[lane*DST_W +: DST_W] = DST_W'(sumW >> shiftAmt);
  end

  always_comb begin
    if (strobe.upper) nextDest = {narrowed, prevDest[HALF_W-1:0]};
    else              nextDest = {prevDest[DEST_W-1:HALF_W], narrowed};
  end

  always_ff @(posedge clk) begin
    if (!rstN)            destOut <= '0;
    else if (strobe.load) destOut <= nextDest;
  end
endmodule

// File: rtl/rsn_unit.sv
module rsn_unit #(
  parameter int LANES = 8,
  parameter int SRC_W = 16,
  parameter int DST_W = 8,
  parameter int SH_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [LANES*SRC_W-1:0]   srcVec,
  input  logic [SH_W-1:0]          shiftAmt,
  input  logic                     upperHalf,
  input  logic [2*LANES*DST_W-1:0] prevDest,
  output logic                     outValid,
  output logic [2*LANES*DST_W-1:0] destOut
);
  rsn_pkg::rsnStrobe_t strobe;

  rsn_control #(.SH_W(SH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .upperHalf(upperHalf),
    .shiftAmt(shiftAmt), .strobe(strobe), .outValid(outValid)
  );

  rsn_datapath #(.LANES(LANES), .SRC_W(SRC_W), .DST_W(DST_W), .SH_W(SH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcVec(srcVec),
    .shiftAmt(shiftAmt), .prevDest(prevDest), .destOut(destOut)
  );
endmodule

// File: rtl/rsn_unit_checker.sv
module rsn_unit_checker #(
  parameter int HALF_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                upperHalf,
  input logic [2*HALF_W-1:0] prevDest,
  input logic                outValid,
  input logic [2*HALF_W-1:0] destOut
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(destOut)); // R8
  AST_LOWER_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !upperHalf) |=> destOut[2*HALF_W-1:HALF_W] == $past(prevDest[2*HALF_W-1:HALF_W])); // R5
  AST_UPPER_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && upperHalf) |=> destOut[HALF_W-1:0] == $past(prevDest[HALF_W-1:0])); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (destOut == '0 && !outValid)); // R9
endmodule

bind rsn_unit rsn_unit_checker #(.HALF_W(LANES*DST_W)) u_rsn_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .upperHalf(upperHalf),
  .prevDest(prevDest), .outValid(outValid), .destOut(destOut)
);

// File: tb/rsn_unit_test.sv
module rsn_unit_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [3:0]   shiftAmt = '0;
  logic         upperHalf = 1'b0;
  logic [127:0] prevDest = '0;
  logic         outValid;
  logic [127:0] destOut;

  int checks = 0;
  int errors = 0;
  logic [127:0] expDest = '0;
  logic         expValid = 1'b0;
  string        curTag = "R9";

  always #5 clk = ~clk;

  rsn_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcVec(srcVec),
    .shiftAmt(shiftAmt), .upperHalf(upperHalf), .prevDest(prevDest),
    .outValid(outValid), .destOut(destOut)
  );

  function automatic logic [7:0] refByte(int x, int s);
    if (s == 0) return 8'(x & 255);
    return 8'(((x + (1 << (s - 1))) >> s) & 255);
  endfunction

  function automatic logic [127:0] refDest(logic [127:0] src, int s, logic up, logic [127:0] prev);
    logic [63:0] bytes;
    for (int i = 0; i < 8; i++) bytes[8*i +: 8] = refByte(int'(src[16*i +: 16]), s);
    return up ? {bytes, prev[63:0]} : {prev[127:64], bytes};
  endfunction

  task automatic compareNow();
    checks++;
    if (destOut !== expDest) begin
      errors++;
      $display("FAIL %s destOut actual=%h expected=%h", curTag, destOut, expDest);
    end
    checks++;
    if (outValid !== expValid) begin
      errors++;
      $display("FAIL %s outValid actual=%b expected=%b", curTag, outValid, expValid);
    end
  endtask

  // One clock: compare the previous step's outcome, then drive the next step.
  task automatic step(input logic v, input logic [127:0] src, input int s,
                      input logic up, input logic [127:0] prev, input string tag);
    @(negedge clk);
    compareNow();
    inValid = v; srcVec = src; shiftAmt = 4'(s); upperHalf = up; prevDest = prev;
    if (v) expDest = refDest(src, s, up, prev);
    expValid = v;
    curTag = tag;
  endtask

  function automatic logic [127:0] fill(logic [15:0] x);
    return {8{x}};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] src;
    logic [127:0] lowRes;
    // R9: reset holds outputs cleared
    repeat (3) begin @(negedge clk); curTag = "R9"; compareNow(); end
    rstN = 1'b1;
    // R3: 0x1234 >> 3 rounded wraps to 0x47
    step(1, fill(16'h1234), 3, 0, '0, "R3");
    // R2: carry out of bit 15 kept
    step(1, fill(16'hFFFF), 1, 0, '1, "R2");
    step(1, fill(16'hFF80), 8, 1, '0, "R2");
    // R4: shift of zero keeps low byte
    step(1, fill(16'hABCD), 0, 0, {128{1'b1}}, "R4");
    // R1: distinct lanes, typical shift 3
    src = 128'h0007_0004_0003_FFFC_8000_00FF_0100_0011;
    step(1, src, 3, 0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R1");
    // R8: idle cycles hold, other inputs ignored
    step(0, ~src, 5, 1, '1, "R8");
    step(0, src, 2, 0, '0, "R8");
    // R5 then R6: two-step packing through prevDest
    src = 128'h0010_0020_0030_0040_0050_0060_0070_0080;
    lowRes = refDest(src, 3, 0, '0);
    step(1, src, 3, 0, '0, "R5");
    step(1, ~src, 3, 1, lowRes, "R6");
    // R7: back-to-back requests with single-cycle valid
    step(1, fill(16'h00FF), 8, 0, '0, "R7");
    step(0, '0, 0, 0, '0, "R7");
    // R1: random sweep
    for (int n = 0; n < 600; n++) begin
      logic [127:0] r;
      r = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, r, int'($urandom % 16), 1'($urandom),
           {$urandom, $urandom, $urandom, $urandom}, "R1");
    end
    // R9: reset mid-run clears outputs
    @(negedge clk); compareNow();
    rstN = 1'b0; inValid = 1'b1; expDest = '0; expValid = 1'b0; curTag = "R9";
    @(negedge clk); compareNow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule